// File: doc/BRIEF.md
# 32-bit Shift and Normalize Unit

This unit takes a 32-bit operand and either shifts it logically by a programmed count or normalizes it. A logical shift can go left or right. Normalizing shifts the operand left until its top bit is one. The operand is viewed as four bytes, and byte 3 holds the most significant eight bits. A single write strobe carries the operand and the control fields together and starts the operation. When the operation ends, `done` pulses for one cycle. At that point `res_out` holds the shifted value. `count_out` holds either the programmed count (for a shift) or the number of shifts performed (for a normalize).

The engine is serial. After one setup cycle it moves the operand two bit positions per clock, and one position on the final odd step. Latency therefore follows the count. The controller has four named states:
- `SN_IDLE` waits for a write.
- `SN_PREP` is the setup cycle, and it detects an operand that is already normalized.
- `SN_STEP` performs the shift steps.
- `SN_FIN` raises `done`.

The transitions are:
- IDLE→PREP on an accepted write.
- PREP→FIN when normalizing an operand whose top bit is already one.
- PREP→STEP otherwise.
- STEP→STEP while work remains.
- STEP→FIN on the last step.
- FIN→IDLE always.

Top module: `shnorm_unit`

## Requirements
- R1: After reset, `busy`, `done`, `res_out` and `count_out` are all zero.
- R2: With `ctl_norm`=0 and `ctl_dir_right`=0, the result is the operand shifted left by `ctl_count`, with zeros filling from bit 0. `ctl_count` must be 1..31.
- R3: With `ctl_norm`=0 and `ctl_dir_right`=1, the result is the operand shifted right by `ctl_count`, with zeros filling from bit 31.
- R4: Count the rising edge that samples the write as edge 1. For a shift by n, `done` is first high after edge ceil(n/2)+2. A count of 1 gives 3 edges and a count of 31 gives 18.
- R5: `done` is high for exactly one cycle. `busy` is high from the cycle after the accepted write through the `done` cycle, and low in the cycle after.
- R6: With `ctl_norm`=1, the operand is shifted left until bit 31 is one. `count_out` then reports the number of shifts performed.
- R7: Normalizing an operand whose bit 31 is already one leaves the value unchanged and reports a count of 0, with `done` after edge 2.
- R8: Normalizing an all-zero operand stops after 31 shifts. The value stays zero, the reported count is 31, and `done` comes after edge 18.
- R9: A normalize that performs n ≥ 1 shifts raises `done` after edge ceil(n/2)+2.
- R10: A write while `busy` is high is ignored. The running operation's result and count are unaffected.
- R11: After a shift, `count_out` holds the programmed shift count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe; starts an operation when idle |
| ctl_norm | input | 1 | 1 = normalize, 0 = shift |
| ctl_dir_right | input | 1 | Shift direction: 1 = right, 0 = left |
| ctl_count | input | 5 | Shift count (1..31); ignored for normalize |
| opnd_in | input | 32 | Operand, byte 3 most significant |
| res_out | output | 32 | Result register |
| count_out | output | 5 | Programmed count, or shifts performed by normalize |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The embedded properties assume that an accepted shift write never carries a count of zero, since such a count has no defined meaning. They also take the operand and control fields as meaningful only in the cycle of an accepted write. The stimulus sets counts only in the range 1..31 for shifts and drives control inputs for a single cycle at idle. Extra writes happen only deliberately while `busy` is high, to show that they are ignored.

// File: rtl/shnorm_pkg.sv
package shnorm_pkg;
    typedef enum logic [1:0] {
        SN_IDLE = 2'd0,
        SN_PREP = 2'd1,
        SN_STEP = 2'd2,
        SN_FIN  = 2'd3
    } sn_state_e;
endpackage

// File: rtl/shnorm_fsm.sv
module shnorm_fsm
    import shnorm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic skip,
    input  logic last,
    output logic load_en,
    output logic step_en,
    output logic busy,
    output logic done
);
    sn_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SN_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SN_IDLE: if (start) state_d = SN_PREP;
            SN_PREP: state_d = skip ? SN_FIN : SN_STEP;
            SN_STEP: if (last) state_d = SN_FIN;
            SN_FIN:  state_d = SN_IDLE;
            default: state_d = SN_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_en = (state_q == SN_IDLE) && start;
        step_en = (state_q == SN_STEP);
        busy    = (state_q != SN_IDLE);
        done    = (state_q == SN_FIN);
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_last_step_fin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && last) |=> done);
endmodule

// File: rtl/shnorm_datapath.sv
module shnorm_datapath #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             step_en,
    input  logic             ld_norm,
    input  logic             ld_dir_right,
    input  logic [CNT_W-1:0] ld_count,
    input  logic [WIDTH-1:0] ld_value,
    output logic [WIDTH-1:0] val_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             skip,
    output logic             last
);
    localparam logic [CNT_W-1:0] MAXC = CNT_W'(WIDTH - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

    logic [CNT_W-1:0] rem_q;
    logic             norm_q, dir_q;
    logic [CNT_W-1:0] amt;
    logic [WIDTH-1:0] nxt_val;
    logic             top2_zero;

    always_comb begin
        top2_zero = (val_q[WIDTH-1 -: 2] == 2'b00);
        if ((rem_q >= TWO) && (!norm_q || top2_zero)) amt = TWO;
        else                                          amt = ONE;
        if (!norm_q && dir_q) nxt_val = val_q >> amt;
        else                  nxt_val = val_q << amt;
        last = (rem_q == amt) || (norm_q && nxt_val[WIDTH-1]);
        skip = norm_q && val_q[WIDTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            cnt_q  <= '0;
            rem_q  <= '0;
            norm_q <= 1'b0;
            dir_q  <= 1'b0;
        end else if (load_en) begin
            val_q  <= ld_value;
            norm_q <= ld_norm;
            dir_q  <= ld_dir_right;
            rem_q  <= ld_norm ? MAXC : ld_count;
            cnt_q  <= ld_norm ? '0 : ld_count;
        end else if (step_en) begin
            val_q <= nxt_val;
            rem_q <= rem_q - amt;
            if (norm_q) cnt_q <= cnt_q + amt;
        end
    end

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> ($stable(val_q) && $stable(cnt_q)));

    p_norm_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && last && norm_q) |=> (val_q[WIDTH-1] || cnt_q == MAXC));
endmodule

// File: rtl/shnorm_unit.sv
module shnorm_unit #(
    parameter int WIDTH = 32,
    parameter int CNT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_norm,
    input  logic             ctl_dir_right,
    input  logic [CNT_W-1:0] ctl_count,
    input  logic [WIDTH-1:0] opnd_in,
    output logic [WIDTH-1:0] res_out,
    output logic [CNT_W-1:0] count_out,
    output logic             busy,
    output logic             done
);
    localparam int LAT_W   = CNT_W + 1;
    localparam int MAX_LAT = WIDTH / 2 + 1;

    logic load_en, step_en, skip, last;

    shnorm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (ctl_wr),
        .skip    (skip),
        .last    (last),
        .load_en (load_en),
        .step_en (step_en),
        .busy    (busy),
        .done    (done)
    );

    shnorm_datapath #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_en      (load_en),
        .step_en      (step_en),
        .ld_norm      (ctl_norm),
        .ld_dir_right (ctl_dir_right),
        .ld_count     (ctl_count),
        .ld_value     (opnd_in),
        .val_q        (res_out),
        .cnt_q        (count_out),
        .skip         (skip),
        .last         (last)
    );

    // Latency window counter for the bound check
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    lat_q <= '0;
        else if (busy) lat_q <= lat_q + 1'b1;
        else           lat_q <= '0;
    end

    p_latency_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q <= LAT_W'(MAX_LAT)));

    p_shift_count_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !busy && !ctl_norm) |-> (ctl_count != '0));
endmodule

// File: tb/test_shnorm_unit.sv
`timescale 1ns/1ps
module test_shnorm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic        ctl_norm = 1'b0;
    logic        ctl_dir_right = 1'b0;
    logic [4:0]  ctl_count = '0;
    logic [31:0] opnd_in = '0;
    logic [31:0] res_out;
    logic [4:0]  count_out;
    logic        busy, done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] res;
        logic [4:0]  cnt;
        int          lat;
        int          wr;
        string       tag_val;
        string       tag_cnt;
        string       tag_lat;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    shnorm_unit i_shnorm_unit (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_norm(ctl_norm),
        .ctl_dir_right(ctl_dir_right), .ctl_count(ctl_count), .opnd_in(opnd_in),
        .res_out(res_out), .count_out(count_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input bit norm, input bit dir, input logic [4:0] n,
                         input logic [31:0] v, input bit poke);
        exp_t e;
        int sh;
        logic [31:0] t;
        @(negedge clk);
        while (busy) @(negedge clk);
        if (norm) begin
            sh = 0;
            t = v;
            while (!t[31] && sh < 31) begin t = t << 1; sh++; end
            e.res = t;
            e.cnt = 5'(sh);
            e.lat = (sh == 0) ? 2 : (sh + 1) / 2 + 2;
            e.tag_val = (v == 0) ? "R8" : (sh == 0) ? "R7" : "R6";
            e.tag_cnt = e.tag_val;
            e.tag_lat = (v == 0) ? "R8" : (sh == 0) ? "R7" : "R9";
        end else begin
            e.res = dir ? (v >> n) : (v << n);
            e.cnt = n;
            e.lat = (int'(n) + 1) / 2 + 2;
            e.tag_val = dir ? "R3" : "R2";
            e.tag_cnt = "R11";
            e.tag_lat = "R4";
        end
        e.wr = cyc + 1;
        ctl_norm = norm; ctl_dir_right = dir; ctl_count = n; opnd_in = v;
        ctl_wr = 1'b1;
        sb.push_back(e);
        @(negedge clk);
        ctl_wr = 1'b0;
        chk(busy == 1'b1, "R5", "busy after write", 32'(busy), 32'd1);
        if (poke) begin
            // R10: writes while busy must be ignored
            ctl_norm = ~norm; ctl_dir_right = ~dir; ctl_count = 5'd3;
            opnd_in = ~v; ctl_wr = 1'b1;
            @(negedge clk);
            opnd_in = 32'h1234_5678;
            @(negedge clk);
            ctl_wr = 1'b0;
        end
    endtask

    // Monitor: compare results as done appears
    bit prev_done = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (prev_done)
                chk(!done && !busy, "R5", "done/busy after pulse",
                    {30'd0, done, busy}, 32'd0);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5", "unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(res_out == e.res, e.tag_val, "result", res_out, e.res);
                    chk(count_out == e.cnt, e.tag_cnt, "count", 32'(count_out), 32'(e.cnt));
                    chk((cyc - e.wr + 1) == e.lat, e.tag_lat, "latency edges",
                        32'(cyc - e.wr + 1), 32'(e.lat));
                end
            end
            prev_done = done;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0, "R1", "busy/done at reset", {30'd0, busy, done}, 32'd0);
        chk(res_out == 0, "R1", "result at reset", res_out, 32'd0);
        chk(count_out == 0, "R1", "count at reset", 32'(count_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && res_out == 0, "R1", "idle after reset", res_out, 32'd0);

        issue(1'b0, 1'b0, 5'd1,  32'h8000_0001, 1'b0); // R2 R4 min
        issue(1'b0, 1'b0, 5'd31, 32'hFFFF_FFFF, 1'b0); // R2 R4 max
        issue(1'b0, 1'b0, 5'd6,  32'h0ABC_DEF1, 1'b0); // R2
        issue(1'b0, 1'b1, 5'd4,  32'hF000_000F, 1'b0); // R3
        issue(1'b0, 1'b1, 5'd31, 32'h8000_0000, 1'b0); // R3 max
        issue(1'b0, 1'b1, 5'd8,  32'hA5A5_1234, 1'b0); // R3 R11
        issue(1'b1, 1'b0, 5'd0,  32'h0000_1234, 1'b0); // R6 R9
        issue(1'b1, 1'b0, 5'd9,  32'h4000_0000, 1'b0); // R6 R9 single shift
        issue(1'b1, 1'b0, 5'd0,  32'h8000_0000, 1'b0); // R7
        issue(1'b1, 1'b0, 5'd0,  32'h0000_0000, 1'b0); // R8
        issue(1'b1, 1'b0, 5'd0,  32'h0000_0001, 1'b0); // R6 R9 31 shifts
        issue(1'b0, 1'b0, 5'd5,  32'h0000_0001, 1'b1); // R10 poke during shift
        issue(1'b1, 1'b0, 5'd0,  32'h0003_0000, 1'b1); // R10 poke during normalize

        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R5", "all results seen", 32'(sb.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule